// File: doc/BRIEF.md
# First-Come Bus Arbiter

This block decides which master drives a shared system bus. The processor owns the bus by default. Two secondary masters compete with it: a DMA engine (requester index 0) and an SDRAM refresh/access controller (requester index 1). Each secondary master raises a request line and may drive the bus only while its acknowledge is high. While a secondary master owns the bus, a hold output freezes the processor. The freeze covers all processor activity, including servicing of non-maskable interrupts.

No requester outranks another. The block records the order in which requests first appear and grants them in that order. The one exception is two requests that first appear at the same clock edge: the lower index (the DMA engine) goes first. An owner gives the bus back by lowering its request. The next waiting master is acknowledged only after one idle cycle. A request that disappears before it is acknowledged is dropped from the waiting list.

The number of requesters is a parameter, and the same ordering rules apply to any count.

Top module: `fcBusArbiter`

## Requirements
- R1: While reset is asserted, and after reset with no request, every bit of `ackOut` is 0 and `holdOut` is 0.
- R2: When a request is first sampled at a clock edge with the bus idle, `holdOut` rises at that edge. `ackOut` bit i (i = 0 for DMA, i = 1 for SDRAM) rises at the following edge, and only for a master whose request was high there.
- R3: At most one bit of `ackOut` is high at any time, and `holdOut` is high whenever any acknowledge is high.
- R4: Waiting requests are acknowledged in the order of the clock edge at which each was first sampled high.
- R5: Requests first sampled at the same edge are served lowest index first, so DMA (bit 0) is served before SDRAM (bit 1).
- R6: While one master is acknowledged, a request from another master gets no acknowledge, however long it waits.
- R7: The owner's acknowledge falls at the first edge that samples its request low. A waiting master is acknowledged at the next edge, leaving exactly one cycle with no acknowledge, and `holdOut` stays high through that cycle. Ownership never moves from one master to another without at least one such cycle.
- R8: `holdOut` falls at the same edge as the last acknowledge when nothing is waiting. It never falls while an acknowledge is high.
- R9: A request withdrawn before it is acknowledged is removed and never granted. If nothing else is owned or waiting, `holdOut` falls at the edge that samples the withdrawal.
- R10: A master that releases the bus and raises its request again takes its place behind any request that was already waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqIn | input | NUM_MASTERS | Bus request per secondary master (bit 0 DMA, bit 1 SDRAM) |
| ackOut | output | NUM_MASTERS | Bus acknowledge per secondary master, at most one high |
| holdOut | output | 1 | Freezes the processor, including non-maskable interrupt handling |

## Verification
The bench builds the block with its default of two requesters. With two requesters, every ordering case can be reached in a few cycles: one master owning while the other waits, a simultaneous first request, a withdrawal while the bus is idle or owned, and an owner that asks again straight after releasing. Directed sequences pin down the exact edge of each acknowledge and hold transition. A long random phase with slowly toggling requests is checked against an arrival-stamp model written inside the bench.

// File: rtl/fcArbPkg.sv
package fcArbPkg;

  // Strobes from the ownership control to the waiting-list datapath.
  typedef struct packed {
    logic pop;   // head of the surviving list is granted at this edge
  } arbStrobes_t;

endpackage

// File: rtl/fcArbArrival.sv
// Flags requests that are newly present: high, not yet waiting, not owning.
module fcArbArrival #(
  parameter int NUM_MASTERS = 2
) (
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] queuedMask,
  input  logic [NUM_MASTERS-1:0] ackMask,
  output logic [NUM_MASTERS-1:0] arrivals
);

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_arr
    assign arrivals[m] = reqIn[m] & ~queuedMask[m] & ~ackMask[m];
  end

endmodule

// File: rtl/fcArbQueue.sv
// Arrival-ordered waiting list. Withdrawn entries are dropped, the list is
// compacted, the head is popped on grant, and new arrivals are appended
// lowest index first.
module fcArbQueue
  import fcArbPkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int IDXW = 1,
  parameter int CNTW = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] arrivals,
  input  arbStrobes_t            strobes,
  output logic [IDXW-1:0]        headIdx,
  output logic                   headValid,
  output logic [NUM_MASTERS-1:0] queuedMask,
  output logic                   nextNonEmpty
);

  logic [IDXW-1:0] slotQ    [NUM_MASTERS];
  logic [IDXW-1:0] keepIdx  [NUM_MASTERS];
  logic [IDXW-1:0] nextSlot [NUM_MASTERS];
  logic [CNTW-1:0] countQ;
  logic [CNTW-1:0] nextCount;
  int              keepCnt;

  // Keep the entries whose request is still high, in their order.
  always_comb begin : compact
    int k;
    k = 0;
    for (int s = 0; s < NUM_MASTERS; s++) keepIdx[s] = '0;
    for (int s = 0; s < NUM_MASTERS; s++) begin
      if (s < int'(countQ) && reqIn[slotQ[s]]) begin
        keepIdx[k] = slotQ[s];
        k++;
      end
    end
    keepCnt = k;
  end

  assign headValid = (keepCnt != 0);
  assign headIdx   = keepIdx[0];

  // Drop the granted head, then append arrivals lowest index first.
  always_comb begin : rebuild
    int n;
    int first;
    n = 0;
    first = strobes.pop ? 1 : 0;
    for (int s = 0; s < NUM_MASTERS; s++) nextSlot[s] = '0;
    for (int s = 0; s < NUM_MASTERS; s++) begin
      if (s >= first && s < keepCnt) begin
        nextSlot[n] = keepIdx[s];
        n++;
      end
    end
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (arrivals[m] && n < NUM_MASTERS) begin
        nextSlot[n] = IDXW'(m);
        n++;
      end
    end
    nextCount = CNTW'(n);
  end

  assign nextNonEmpty = (nextCount != '0);

  always_comb begin : maskBuild
    queuedMask = '0;
    for (int s = 0; s < NUM_MASTERS; s++) begin
      if (s < int'(countQ)) queuedMask[slotQ[s]] = 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_MASTERS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) slotQ[s] <= '0;
      else       slotQ[s] <= nextSlot[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else       countQ <= nextCount;
  end

endmodule

// File: rtl/fcArbCtrl.sv
// Ownership control: owner register, acknowledge decode and processor hold.
module fcArbCtrl
  import fcArbPkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int IDXW = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic                   headValid,
  input  logic [IDXW-1:0]        headIdx,
  input  logic                   nextNonEmpty,
  output arbStrobes_t            strobes,
  output logic [NUM_MASTERS-1:0] ackOut,
  output logic                   holdOut
);

  logic            ownerValid;
  logic [IDXW-1:0] ownerIdx;
  logic            holdQ;
  logic            releaseNow;
  logic            grantNow;
  logic            ownerNext;

  // A grant needs the bus free and the hold already high for a cycle.
  assign releaseNow  = ownerValid && !reqIn[ownerIdx];
  assign grantNow    = !ownerValid && holdQ && headValid;
  assign ownerNext   = grantNow || (ownerValid && !releaseNow);
  assign strobes.pop = grantNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerValid <= 1'b0;
      ownerIdx   <= '0;
      holdQ      <= 1'b0;
    end else begin
      if (releaseNow) begin
        ownerValid <= 1'b0;
      end else if (grantNow) begin
        ownerValid <= 1'b1;
        ownerIdx   <= headIdx;
      end
      holdQ <= ownerNext || nextNonEmpty;
    end
  end

  assign ackOut  = ownerValid ? (NUM_MASTERS'(1) << ownerIdx) : '0;
  assign holdOut = holdQ;

endmodule

// File: rtl/fcBusArbiter.sv
module fcBusArbiter
  import fcArbPkg::*;
#(
  parameter int NUM_MASTERS = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  output logic [NUM_MASTERS-1:0] ackOut,
  output logic                   holdOut
);

  localparam int IDXW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam int CNTW = $clog2(NUM_MASTERS + 1);

  arbStrobes_t            strobes;
  logic [IDXW-1:0]        headIdx;
  logic                   headValid;
  logic                   nextNonEmpty;
  logic [NUM_MASTERS-1:0] queuedMask;
  logic [NUM_MASTERS-1:0] arrivals;

  fcArbArrival #(.NUM_MASTERS(NUM_MASTERS)) u_arrival (
    .reqIn      (reqIn),
    .queuedMask (queuedMask),
    .ackMask    (ackOut),
    .arrivals   (arrivals)
  );

  fcArbQueue #(.NUM_MASTERS(NUM_MASTERS), .IDXW(IDXW), .CNTW(CNTW)) u_queue (
    .clk          (clk),
    .rstN         (rstN),
    .reqIn        (reqIn),
    .arrivals     (arrivals),
    .strobes      (strobes),
    .headIdx      (headIdx),
    .headValid    (headValid),
    .queuedMask   (queuedMask),
    .nextNonEmpty (nextNonEmpty)
  );

  fcArbCtrl #(.NUM_MASTERS(NUM_MASTERS), .IDXW(IDXW)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqIn        (reqIn),
    .headValid    (headValid),
    .headIdx      (headIdx),
    .nextNonEmpty (nextNonEmpty),
    .strobes      (strobes),
    .ackOut       (ackOut),
    .holdOut      (holdOut)
  );

endmodule

// File: rtl/fcArbChecker.sv
module fcArbChecker #(
  parameter int NUM_MASTERS = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_MASTERS-1:0] reqIn,
  input logic [NUM_MASTERS-1:0] ackOut,
  input logic                   holdOut
);

  assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOut));

  assert_ack_needs_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|ackOut) |-> holdOut);

  assert_hold_leads_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|ackOut) |-> $past(holdOut));

  assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((ackOut & ~$past(ackOut) & ~$past(reqIn)) == '0));

  assert_release_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((ackOut & ~reqIn) != '0) |=> (ackOut == '0));

  assert_no_direct_handover_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|ackOut) |=> ((ackOut == $past(ackOut)) || (ackOut == '0)));

  assert_hold_falls_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdOut) |-> (ackOut == '0));

endmodule

bind fcBusArbiter fcArbChecker #(.NUM_MASTERS(NUM_MASTERS)) u_fcArbChecker (
  .clk     (clk),
  .rstN    (rstN),
  .reqIn   (reqIn),
  .ackOut  (ackOut),
  .holdOut (holdOut)
);

// File: tb/fcBusArbiter_bench.sv
module fcBusArbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM = 2;
  localparam int RAND_CYCLES = 4000;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NUM-1:0] reqIn = '0;
  logic [NUM-1:0] ackOut;
  logic           holdOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Arrival-stamp model of the requirements.
  bit pend [NUM];
  int stamp [NUM];
  int own = -1;
  bit holdM = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcBusArbiter #(.NUM_MASTERS(NUM)) u_fcBusArbiter (
    .clk (clk), .rstN (rstN), .reqIn (reqIn), .ackOut (ackOut), .holdOut (holdOut)
  );

  function automatic void modelStep(logic [NUM-1:0] r);
    bit arr [NUM];
    int best;
    bit rel;
    best = -1;
    for (int p = 0; p < NUM; p++) arr[p] = r[p] && !pend[p] && (own != p);
    rel = (own >= 0) && !r[own];
    if (rel) own = -1;
    else if (own < 0 && holdM) begin
      for (int p = 0; p < NUM; p++)
        if (pend[p] && r[p] && (best < 0 || stamp[p] < stamp[best])) best = p;
      if (best >= 0) begin own = best; pend[best] = 0; end
    end
    for (int p = 0; p < NUM; p++) if (pend[p] && !r[p]) pend[p] = 0;
    for (int p = 0; p < NUM; p++) if (arr[p]) begin pend[p] = 1; stamp[p] = cyc; end
    cyc++;
    holdM = (own >= 0);
    for (int p = 0; p < NUM; p++) if (pend[p]) holdM = 1;
  endfunction

  function automatic logic [NUM-1:0] modelAck();
    return (own >= 0) ? (NUM'(1) << own) : '0;
  endfunction

  task automatic expectOut(logic [NUM-1:0] expAck, logic expHold, string tag);
    checks++;
    if (ackOut !== expAck || holdOut !== expHold) begin
      errors++;
      $display("FAIL %s: ack=%b hold=%b expected ack=%b hold=%b",
               tag, ackOut, holdOut, expAck, expHold);
    end
  endtask

  // Drive one request pattern for one edge, then sample at the falling edge.
  task automatic step(logic [NUM-1:0] r);
    reqIn = r;
    @(posedge clk);
    modelStep(r);
    @(negedge clk);
  endtask

  task automatic stepCheck(logic [NUM-1:0] r, logic [NUM-1:0] expAck,
                           logic expHold, string tag);
    step(r);
    expectOut(expAck, expHold, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    logic [NUM-1:0] rv;
    void'($urandom(32'd20240611));
    for (int p = 0; p < NUM; p++) begin pend[p] = 0; stamp[p] = 0; end
    reqIn = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectOut('0, 1'b0, "R1 during reset");
    rstN = 1'b1;
    stepCheck(2'b00, 2'b00, 1'b0, "R1 idle after reset");

    // R2: idle grant timing
    stepCheck(2'b01, 2'b00, 1'b1, "R2 hold before ack");
    stepCheck(2'b01, 2'b01, 1'b1, "R2 ack one edge after hold");
    // R6: other request waits
    stepCheck(2'b11, 2'b01, 1'b1, "R6 sdram waits");
    stepCheck(2'b11, 2'b01, 1'b1, "R6 sdram still waits");
    stepCheck(2'b11, 2'b01, 1'b1, "R6 sdram still waits later");
    // R7: release, gap, next grant
    stepCheck(2'b10, 2'b00, 1'b1, "R7 ack drops, hold stays");
    stepCheck(2'b10, 2'b10, 1'b1, "R7 waiting master granted after gap");
    // R8: last release
    stepCheck(2'b00, 2'b00, 1'b0, "R8 hold falls with last ack");

    // R5: simultaneous first requests
    stepCheck(2'b11, 2'b00, 1'b1, "R5 tie hold");
    stepCheck(2'b11, 2'b01, 1'b1, "R5 tie goes to dma");
    stepCheck(2'b10, 2'b00, 1'b1, "R5 gap after dma");
    stepCheck(2'b10, 2'b10, 1'b1, "R5 sdram second");
    stepCheck(2'b00, 2'b00, 1'b0, "R8 idle after tie");

    // R4: sdram first, dma later
    stepCheck(2'b10, 2'b00, 1'b1, "R4 sdram arrives");
    stepCheck(2'b11, 2'b10, 1'b1, "R4 earlier sdram granted");
    stepCheck(2'b01, 2'b00, 1'b1, "R4 sdram releases");
    stepCheck(2'b01, 2'b01, 1'b1, "R4 later dma granted");
    stepCheck(2'b00, 2'b00, 1'b0, "R8 idle after order test");

    // R9: withdrawal while idle
    stepCheck(2'b10, 2'b00, 1'b1, "R9 request seen");
    stepCheck(2'b00, 2'b00, 1'b0, "R9 withdrawn from idle");
    stepCheck(2'b00, 2'b00, 1'b0, "R9 never granted");
    // R9: withdrawal while waiting behind owner
    stepCheck(2'b01, 2'b00, 1'b1, "R9 owner setup");
    stepCheck(2'b01, 2'b01, 1'b1, "R9 owner acked");
    stepCheck(2'b11, 2'b01, 1'b1, "R9 sdram waits");
    stepCheck(2'b01, 2'b01, 1'b1, "R9 sdram withdraws");
    stepCheck(2'b00, 2'b00, 1'b0, "R9 nothing left after release");
    stepCheck(2'b00, 2'b00, 1'b0, "R9 withdrawn sdram not granted");

    // R10: owner asks again right after releasing
    stepCheck(2'b01, 2'b00, 1'b1, "R10 setup");
    stepCheck(2'b01, 2'b01, 1'b1, "R10 dma owns");
    stepCheck(2'b11, 2'b01, 1'b1, "R10 sdram waits");
    stepCheck(2'b10, 2'b00, 1'b1, "R10 dma releases");
    stepCheck(2'b11, 2'b10, 1'b1, "R10 sdram granted, dma reasks");
    stepCheck(2'b01, 2'b00, 1'b1, "R10 sdram releases");
    stepCheck(2'b01, 2'b01, 1'b1, "R10 reasking dma granted after");
    stepCheck(2'b00, 2'b00, 1'b0, "R10 idle");

    // Random phase against the model (R3 R4 R6 R7 R9)
    rv = '0;
    for (int c = 0; c < RAND_CYCLES; c++) begin
      for (int p = 0; p < NUM; p++)
        if ($urandom % 4 == 0) rv[p] = ~rv[p];
      step(rv);
      expectOut(modelAck(), holdM, "R4 random against model");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule